// File: doc/BRIEF.md
# Vectored Interrupt Controller with Non-Maskable Converter Interrupt

This block collects interrupt requests for a small microcontroller core. Seven sources feed it: two external pins, each watched for one edge direction fixed at build time; overflow pulses from two timers; a periodic time base tick; a real-time clock tick; and an active-low end-of-conversion line from an analog-to-digital converter. Each maskable source has a request flag and an enable bit. One global enable gates all maskable sources. All of these live in two 8-bit registers that software reads and writes through a simple port.

When a source is allowed through, the block raises a one-clock take strobe together with a vector address. The CPU pushes its program counter and branches to that vector. Taking any interrupt clears that source's request and the global enable in the same clock edge, so nesting stays blocked until software enables it again. The converter interrupt is non-maskable. It ignores the global enable and the stack-full indication. The CPU holds a busy input high between instruction boundaries, and no interrupt is taken while it is high.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset both registers read 0x00, `irq_take` is low and `irq_vec` is 0.
- R2: Register 0 holds, from bit 0 upward: global enable, ext0 enable, ext1 enable, timer0 enable, ext0 flag, ext1 flag, timer0 flag, converter enable. Register 1 holds timer1 enable (bit 0), time base enable (bit 1), RTC enable (bit 2), timer1 flag (bit 4), time base flag (bit 5) and RTC flag (bit 6). Bits 3 and 7 of register 1 always read 0. A write sets or clears every writable bit.
- R3: An external pin sets its flag on its configured edge: falling when its `EXT_RISE` bit is 0, rising when it is 1. The opposite edge has no effect.
- R4: A one-cycle high pulse on a timer overflow, the time base tick or the RTC tick sets that source's flag.
- R5: A maskable source is taken only when the global enable, its own enable and its flag are all 1 and `stack_full` is 0.
- R6: Taking an interrupt clears the taken source's flag and the global enable at the same clock edge that raises `irq_take`. `irq_take` stays high for exactly one clock.
- R7: While the global enable is 0, requests still set their flags. A pending flag is served once software sets the global enable.
- R8: A falling edge of `adc_eoc_n` while the converter enable is 1 causes a take with vector 0x1C. This happens whatever the global enable and `stack_full` are. While the converter enable is 0, the edge causes no take.
- R9: When several sources are eligible together, they are served in this order: converter, ext0, ext1, timer0, timer1, time base, RTC.
- R10: If a hardware request and a software write of 0 hit the same flag in the same cycle, the flag ends up 1.
- R11: No interrupt is taken while `cpu_busy` is high. A pending interrupt is taken at the first edge where `cpu_busy` is low.
- R12: The vectors are ext0 0x04, ext1 0x08, timer0 0x0C, timer1 0x10, time base 0x14, RTC 0x18 and converter 0x1C.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select (0 or 1) |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data of the selected register (combinational) |
| ext_pin | input | 2 | External interrupt pins |
| tmr_ovf | input | 2 | Timer overflow pulses (bit 0 timer0, bit 1 timer1) |
| tbase_tick | input | 1 | Time base tick pulse |
| rtc_tick | input | 1 | Real-time clock tick pulse |
| adc_eoc_n | input | 1 | Converter end-of-conversion, active low |
| stack_full | input | 1 | CPU return stack is full |
| cpu_busy | input | 1 | CPU is not at an instruction boundary |
| irq_take | output | 1 | One-clock interrupt-taken strobe |
| irq_vec | output | VEC_W | Vector address that goes with the strobe |

## Verification
The bench targets several specific faults:

- **Priority.** It sets every flag at once and then re-enables globally after each take, walking the full priority ladder. A wrong priority order or a wrong vector table would show up as an out-of-order vector.
- **Edge detection.** One pin is built for a rising edge and the other for a falling edge, and both directions are applied to each pin. A design that detects levels, or ignores the build option, would raise a flag on the wrong edge.
- **Gating and strobe length.** The bench holds `stack_full`, the global enable and `cpu_busy` against a pending flag, one at a time. A gating fault would either take the interrupt early or lose it. A strobe longer than one clock would be caught as a second take.
- **Converter interrupt.** It is fired with the global enable at 0 and the stack full, which catches any design that masks it.
- **Hardware set against software clear.** A same-cycle collision between a hardware set and a software clear would expose a design in which the write wins.

// File: rtl/irq_vector_pkg.sv
package irq_vector_pkg;

   // Source order is also service priority: lower index wins.
   localparam int NUM_SRC  = 7;
   localparam int MASK_N   = NUM_SRC - 1;
   localparam int SRC_IDXW = $clog2(NUM_SRC);

   typedef enum logic [SRC_IDXW-1:0] {
      SRC_ADC   = 3'd0,
      SRC_EXT0  = 3'd1,
      SRC_EXT1  = 3'd2,
      SRC_TMR0  = 3'd3,
      SRC_TMR1  = 3'd4,
      SRC_TBASE = 3'd5,
      SRC_RTC   = 3'd6
   } irq_src_e;

   // Maskable source k sits at k*step; the converter sits after the last one.
   function automatic logic [15:0] vector_for(int idx, int step);
      int v;
      v = (idx == int'(SRC_ADC)) ? NUM_SRC * step : idx * step;
      return v[15:0];
   endfunction

endpackage

// File: rtl/irq_edge_sense.sv
module irq_edge_sense #(
   parameter bit RISING = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   output logic hit
);

   // Reset to the idle level so that leaving reset makes no spurious edge.
   localparam logic IDLE_LVL = RISING ? 1'b0 : 1'b1;

   logic prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= IDLE_LVL;
      else        prev_q <= pin;
   end

   generate
      if (RISING) begin : g_rise
         assign hit = pin & ~prev_q;
      end else begin : g_fall
         assign hit = ~pin & prev_q;
      end
   endgenerate

endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
   parameter int N    = 7,
   localparam int IDXW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]    req,
   output logic [N-1:0]    grant,
   output logic [IDXW-1:0] idx,
   output logic            any
);

   generate
      if (N < 2) begin : g_bad_n
         $error("irq_prio_pick needs at least two requesters");
      end
   endgenerate

   always_comb begin
      logic seen;
      grant = '0;
      idx   = '0;
      seen  = 1'b0;
      for (int i = 0; i < N; i++) begin
         if (req[i] && !seen) begin
            grant[i] = 1'b1;
            idx      = i[IDXW-1:0];
            seen     = 1'b1;
         end
      end
      any = seen;
   end

endmodule

// File: rtl/irq_ctl_regs.sv
module irq_ctl_regs
   import irq_vector_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic              addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [MASK_N-1:0] hw_set,
   input  logic [MASK_N-1:0] take_clr,
   input  logic              take_any,
   output logic [DATA_W-1:0] rdata,
   output logic [MASK_N-1:0] en_o,
   output logic [MASK_N-1:0] flag_o,
   output logic              gie_o,
   output logic              adc_en_o
);

   // The first three maskable sources live in bank 0, the rest in bank 1.
   localparam int BANK0_CNT = 3;

   generate
      if (DATA_W != 8) begin : g_bad_w
         $error("irq_ctl_regs: register layout is fixed at 8 bits");
      end
      if (MASK_N != 2 * BANK0_CNT) begin : g_bad_n
         $error("irq_ctl_regs: layout assumes six maskable sources");
      end
   endgenerate

   logic [DATA_W-1:0] img0, img1;
   logic              gie_q, adc_en_q;
   logic              wr0, wr1;

   assign wr0 = wr && (addr == 1'b0);
   assign wr1 = wr && (addr == 1'b1);

   // Global enable: a take clears it, and the clear outranks a write.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        gie_q <= 1'b0;
      else if (take_any) gie_q <= 1'b0;
      else if (wr0)      gie_q <= wdata[0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   adc_en_q <= 1'b0;
      else if (wr0) adc_en_q <= wdata[DATA_W-1];
   end

   genvar j;
   generate
      for (j = 0; j < MASK_N; j++) begin : g_src
         localparam bit HI_BANK = (j >= BANK0_CNT);
         localparam int EN_POS  = HI_BANK ? (j - BANK0_CNT) : (j + 1);
         localparam int FL_POS  = HI_BANK ? (j + 1) : (j + 1 + BANK0_CNT);

         logic en_r, flag_r, bank_wr;

         assign bank_wr = HI_BANK ? wr1 : wr0;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       en_r <= 1'b0;
            else if (bank_wr) en_r <= wdata[EN_POS];
         end

         // Hardware set outranks both the take clear and a software write.
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)           flag_r <= 1'b0;
            else if (hw_set[j])   flag_r <= 1'b1;
            else if (take_clr[j]) flag_r <= 1'b0;
            else if (bank_wr)     flag_r <= wdata[FL_POS];
         end

         assign en_o[j]   = en_r;
         assign flag_o[j] = flag_r;

         if (HI_BANK) begin : g_hi
            assign img1[EN_POS] = en_r;
            assign img1[FL_POS] = flag_r;
         end else begin : g_lo
            assign img0[EN_POS] = en_r;
            assign img0[FL_POS] = flag_r;
         end
      end
   endgenerate

   assign img0[0]          = gie_q;
   assign img0[DATA_W-1]   = adc_en_q;
   assign img1[BANK0_CNT]  = 1'b0;
   assign img1[DATA_W-1]   = 1'b0;

   assign rdata    = addr ? img1 : img0;
   assign gie_o    = gie_q;
   assign adc_en_o = adc_en_q;

endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
   import irq_vector_pkg::*;
#(
   parameter int       DATA_W   = 8,
   parameter int       VEC_W    = 8,
   parameter int       VEC_STEP = 4,
   parameter bit [1:0] EXT_RISE = 2'b00
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic [1:0]        ext_pin,
   input  logic [1:0]        tmr_ovf,
   input  logic              tbase_tick,
   input  logic              rtc_tick,
   input  logic              adc_eoc_n,
   input  logic              stack_full,
   input  logic              cpu_busy,
   output logic              irq_take,
   output logic [VEC_W-1:0]  irq_vec
);

   localparam int NUM_EXT = 2;
   localparam int MAX_VEC = NUM_SRC * VEC_STEP;

   generate
      if (VEC_W > 16 || VEC_W < 1) begin : g_bad_vw
         $error("irq_vector_ctrl: VEC_W must be 1..16");
      end
      if (MAX_VEC >= (1 << VEC_W)) begin : g_bad_step
         $error("irq_vector_ctrl: vectors do not fit in VEC_W bits");
      end
   endgenerate

   logic [NUM_EXT-1:0]  ext_hit;
   logic                adc_hit;
   logic [MASK_N-1:0]   hw_set, en_w, flag_w, mask_req, take_clr;
   logic                gie_w, adc_en_w, adc_pend_q;
   logic [NUM_SRC-1:0]  req, grant;
   logic [SRC_IDXW-1:0] win_idx;
   logic                win_any, fire;
   logic [15:0]         vec_full;
   logic                take_q;
   logic [VEC_W-1:0]    vec_q;

   genvar e;
   generate
      for (e = 0; e < NUM_EXT; e++) begin : g_ext
         irq_edge_sense #(.RISING(EXT_RISE[e])) u_edge (
            .clk   (clk),
            .rst_n (rst_n),
            .pin   (ext_pin[e]),
            .hit   (ext_hit[e])
         );
      end
   endgenerate

   irq_edge_sense #(.RISING(1'b0)) u_adc_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .pin   (adc_eoc_n),
      .hit   (adc_hit)
   );

   // Maskable request inputs, in source order ext0..rtc.
   assign hw_set = {rtc_tick, tbase_tick, tmr_ovf[1], tmr_ovf[0], ext_hit[1], ext_hit[0]};

   irq_ctl_regs #(.DATA_W(DATA_W)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr       (reg_wr),
      .addr     (reg_addr),
      .wdata    (reg_wdata),
      .hw_set   (hw_set),
      .take_clr (take_clr),
      .take_any (fire),
      .rdata    (reg_rdata),
      .en_o     (en_w),
      .flag_o   (flag_w),
      .gie_o    (gie_w),
      .adc_en_o (adc_en_w)
   );

   // Converter pending bit: no visible flag, dropped when its enable drops.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  adc_pend_q <= 1'b0;
      else if (!adc_en_w)          adc_pend_q <= 1'b0;
      else if (adc_hit)            adc_pend_q <= 1'b1;
      else if (fire && grant[0])   adc_pend_q <= 1'b0;
   end

   assign mask_req = flag_w & en_w & {MASK_N{gie_w & ~stack_full}};
   assign req      = {mask_req, adc_pend_q};

   irq_prio_pick #(.N(NUM_SRC)) u_pick (
      .req   (req),
      .grant (grant),
      .idx   (win_idx),
      .any   (win_any)
   );

   assign fire     = win_any & ~cpu_busy;
   assign take_clr = grant[NUM_SRC-1:1] & {MASK_N{fire}};
   assign vec_full = vector_for(int'(win_idx), VEC_STEP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         take_q <= 1'b0;
         vec_q  <= '0;
      end else begin
         take_q <= fire;
         if (fire) vec_q <= vec_full[VEC_W-1:0];
      end
   end

   assign irq_take = take_q;
   assign irq_vec  = vec_q;

endmodule

// File: rtl/irq_vector_ctrl_chk.sv
module irq_vector_ctrl_chk
   import irq_vector_pkg::*;
#(
   parameter int VEC_W    = 8,
   parameter int VEC_STEP = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             irq_take,
   input logic [VEC_W-1:0] irq_vec,
   input logic             cpu_busy,
   input logic             stack_full,
   input logic             reg_addr,
   input logic [7:0]       reg_rdata,
   input logic             gie
);

   localparam logic [VEC_W-1:0] NMI_VEC = VEC_W'(NUM_SRC * VEC_STEP);
   localparam logic [VEC_W-1:0] MIN_VEC = VEC_W'(VEC_STEP);

   // R6
   gie_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_take |-> !gie);

   // R11
   busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_busy |=> !irq_take);

   // R5
   mask_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_take && irq_vec != NMI_VEC) |-> ($past(gie) && !$past(stack_full)));

   // R2
   unused_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reg_addr |-> (reg_rdata[3] == 1'b0 && reg_rdata[7] == 1'b0));

   // R12
   vec_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_take |-> (irq_vec >= MIN_VEC && irq_vec <= NMI_VEC
                    && (int'(irq_vec) % VEC_STEP) == 0));

endmodule

bind irq_vector_ctrl irq_vector_ctrl_chk #(.VEC_W(VEC_W), .VEC_STEP(VEC_STEP)) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .irq_take   (irq_take),
   .irq_vec    (irq_vec),
   .cpu_busy   (cpu_busy),
   .stack_full (stack_full),
   .reg_addr   (reg_addr),
   .reg_rdata  (reg_rdata[7:0]),
   .gie        (gie_w)
);

// File: tb/irq_vector_ctrl_tb_top.sv
module irq_vector_ctrl_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int STEP       = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_wr = 1'b0;
   logic       reg_addr = 1'b0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic [1:0] ext_pin = 2'b01;   // ext0 falling (idle high), ext1 rising (idle low)
   logic [1:0] tmr_ovf = '0;
   logic       tbase_tick = 1'b0;
   logic       rtc_tick = 1'b0;
   logic       adc_eoc_n = 1'b1;
   logic       stack_full = 1'b0;
   logic       cpu_busy = 1'b0;
   logic       irq_take;
   logic [7:0] irq_vec;

   int n_chk  = 0;
   int n_fail = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   irq_vector_ctrl #(
      .DATA_W(8), .VEC_W(8), .VEC_STEP(STEP), .EXT_RISE(2'b10)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ext_pin(ext_pin),
      .tmr_ovf(tmr_ovf), .tbase_tick(tbase_tick), .rtc_tick(rtc_tick),
      .adc_eoc_n(adc_eoc_n), .stack_full(stack_full), .cpu_busy(cpu_busy),
      .irq_take(irq_take), .irq_vec(irq_vec)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic a, input logic [7:0] d);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic a, output int d);
      reg_addr = a;
      #1;
      d = int'(reg_rdata);
   endtask

   task automatic no_take(input string req, input int cycles);
      for (int i = 0; i < cycles; i++) begin
         tick(1);
         chk(req, int'(irq_take), 0);
      end
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      int v;
      logic [5:0] rem;
      tick(3);
      rst_n = 1'b1;
      tick(1);

      // R1 reset state
      rd(0, v); chk("R1 reg0", v, 8'h00);
      rd(1, v); chk("R1 reg1", v, 8'h00);
      chk("R1 take", int'(irq_take), 0);
      chk("R1 vec", int'(irq_vec), 0);

      // R2 layout and unused bits
      wr(0, 8'h8E); rd(0, v); chk("R2 reg0 rw", v, 8'h8E);
      wr(1, 8'hFF); rd(1, v); chk("R2 reg1 unused zero", v, 8'h77);
      wr(1, 8'h00); rd(1, v); chk("R2 reg1 clear", v, 8'h00);
      wr(0, 8'h00); rd(0, v); chk("R2 reg0 clear", v, 8'h00);

      // R3 edge selection: ext0 falling, ext1 rising
      ext_pin[0] = 1'b0; tick(1); rd(0, v); chk("R3 ext0 fall sets", v, 8'h10);
      wr(0, 8'h00);
      ext_pin[0] = 1'b1; tick(1); rd(0, v); chk("R3 ext0 rise ignored", v, 8'h00);
      ext_pin[1] = 1'b1; tick(1); rd(0, v); chk("R3 ext1 rise sets", v, 8'h20);
      wr(0, 8'h00);
      ext_pin[1] = 1'b0; tick(1); rd(0, v); chk("R3 ext1 fall ignored", v, 8'h00);

      // R4 pulse sources
      tmr_ovf[0] = 1'b1; tick(1); tmr_ovf[0] = 1'b0;
      rd(0, v); chk("R4 timer0 flag", v, 8'h40);
      wr(0, 8'h00);
      tmr_ovf[1] = 1'b1; tick(1); tmr_ovf[1] = 1'b0;
      rd(1, v); chk("R4 timer1 flag", v, 8'h10);
      tbase_tick = 1'b1; tick(1); tbase_tick = 1'b0;
      rd(1, v); chk("R4 time base flag", v, 8'h30);
      rtc_tick = 1'b1; tick(1); rtc_tick = 1'b0;
      rd(1, v); chk("R4 rtc flag", v, 8'h70);
      wr(1, 8'h00);

      // R10 hardware set beats software clear
      reg_wr = 1'b1; reg_addr = 1'b1; reg_wdata = 8'h00; tmr_ovf[1] = 1'b1;
      tick(1);
      reg_wr = 1'b0; tmr_ovf[1] = 1'b0;
      rd(1, v); chk("R10 set wins", v, 8'h10);
      wr(1, 8'h00); rd(1, v); chk("R10 plain clear", v, 8'h00);

      // R7 flags collect while global enable is 0
      wr(1, 8'h01);
      tmr_ovf[1] = 1'b1; tick(1); tmr_ovf[1] = 1'b0;
      no_take("R7 held while masked", 3);
      rd(1, v); chk("R7 flag pending", v, 8'h11);
      wr(0, 8'h01); tick(1);
      chk("R7 take after enable", int'(irq_take), 1);
      chk("R12 timer1 vector", int'(irq_vec), 4 * STEP);
      rd(1, v); chk("R6 flag cleared", v, 8'h01);
      rd(0, v); chk("R6 global enable cleared", v, 8'h00);
      tick(1); chk("R6 one-cycle strobe", int'(irq_take), 0);
      wr(1, 8'h00);

      // R5 gating by stack_full and own enable
      stack_full = 1'b1;
      wr(0, 8'h13);
      no_take("R5 stack full blocks", 3);
      stack_full = 1'b0; tick(1);
      chk("R5 take when stack frees", int'(irq_take), 1);
      chk("R12 ext0 vector", int'(irq_vec), 1 * STEP);
      tick(1);
      wr(0, 8'h11);
      no_take("R5 own enable blocks", 3);
      rd(0, v); chk("R5 flag kept", v, 8'h11);
      wr(0, 8'h00);

      // R11 busy suppresses the take
      cpu_busy = 1'b1;
      wr(0, 8'h13);
      no_take("R11 busy holds", 4);
      cpu_busy = 1'b0; tick(1);
      chk("R11 take at boundary", int'(irq_take), 1);
      chk("R11 vector", int'(irq_vec), 1 * STEP);
      tick(1);
      wr(0, 8'h00);

      // R8 converter interrupt ignores global enable and stack_full
      wr(0, 8'h80);
      stack_full = 1'b1;
      adc_eoc_n = 1'b0; tick(2);
      chk("R8 nmi take", int'(irq_take), 1);
      chk("R8 nmi vector", int'(irq_vec), 7 * STEP);
      adc_eoc_n = 1'b1; tick(1);
      chk("R8 strobe ends", int'(irq_take), 0);
      stack_full = 1'b0;
      wr(0, 8'h00);
      adc_eoc_n = 1'b0;
      no_take("R8 disabled no take", 3);
      adc_eoc_n = 1'b1; tick(1);

      // R9 priority ladder with all sources pending
      wr(1, 8'h77);
      wr(0, 8'hFE);
      adc_eoc_n = 1'b0; tick(2);
      chk("R9 converter first", int'(irq_take), 1);
      chk("R9 converter vector", int'(irq_vec), 7 * STEP);
      adc_eoc_n = 1'b1;
      tick(1);
      rem = 6'b111111;
      for (int s = 1; s <= 6; s++) begin
         wr(0, 8'h8F | {1'b0, rem[2], rem[1], rem[0], 4'h0});
         tick(1);
         chk("R9 take", int'(irq_take), 1);
         chk("R9 order vector", int'(irq_vec), s * STEP);
         rem[s-1] = 1'b0;
         tick(1);
         chk("R6 strobe single", int'(irq_take), 0);
      end
      rd(0, v); chk("R9 reg0 drained", v, 8'h8E);
      rd(1, v); chk("R9 reg1 drained", v, 8'h07);

      tick(2);
      finish_run();
   end

endmodule